// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave that behaves like a 256-byte serial EEPROM on a two-wire bus. The system clock samples SCL and SDA. SDA is driven open-drain: when `sda_oe_o` is high, the pad pulls the line low. Three strap inputs set the low bits of the device address, so up to eight such slaves can share one bus.

A write transfer carries a control byte, a word address and any number of data bytes. These bytes land in a 16-entry page buffer. Each entry is indexed by the low four address bits, and the address wraps inside the page. The Stop that closes a write starts a self-timed programming cycle of `TWR_CLKS` system clocks. The buffered bytes are copied into the array when that cycle ends. While the cycle runs, the slave gives no acknowledge at all.

A read transfer returns bytes from an internal address pointer. The pointer increments after every byte and wraps across the whole array. A write-protect input allows write transfers to complete on the bus but prevents any change to the array.

The bus pins have no valid/ready handshake. Flow control is the bus's own acknowledge bit. The master stops a read by withholding its acknowledge. The slave refuses further traffic while it is busy by withholding its own acknowledge.

Top module: `eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is low and every array location reads 0xFF.
- R2: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. `sda_oe_o` changes only while SCL is low. Bits clocked without a preceding Start are ignored and are not acknowledged.
- R3: The first byte after a Start is the control byte. Bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a mismatch the slave does not acknowledge and leaves SDA released until the next Start.
- R4: For every byte it accepts in a write transfer (control, word address, data), the slave holds `sda_oe_o` high throughout the ninth SCL pulse.
- R5: In a write, the byte after the control byte sets the word address. Each following data byte goes to the current address. The low four address bits then increment and wrap inside the same 16-byte page; the upper four bits stay fixed.
- R6: When more than 16 data bytes arrive in one write, only the last 16 are kept. A newer byte replaces the older byte in the same page slot.
- R7: A Stop that ends a write with at least one data byte starts a programming cycle of `TWR_CLKS` clocks. The array changes when that cycle ends. During the cycle the slave acknowledges no byte, its own control byte included.
- R8: While `wp_i` is high, write transfers are still acknowledged. The Stop starts no programming cycle, and no array location changes.
- R9: A random read works as follows: a write control byte, then a word address, then a repeated Start and a read control byte. The slave then returns bytes from that address, incrementing after each byte and rolling from 255 to 0.
- R10: A read that directly follows a Start continues from the address after the last byte read.
- R11: After a read byte that the master does not acknowledge, the slave releases SDA and drives nothing until the next Start.
- R12: A write transfer that carries only a word address starts no programming cycle. The slave acknowledges its control byte right after the Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | Write protect; high blocks all array changes |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench drives directed transfers that separate similar behaviours:
- A single-byte write is distinguished from a page write that wraps at the page boundary.
- A 20-byte burst shows whether the slave keeps the newest or the oldest bytes of a slot.
- An address-only write checks that no programming cycle starts.
- A protected write must still be acknowledged while leaving no trace in the array.

Polling the control byte right after a Stop shows whether a programming cycle is running. A read across address 255 tells a full-array wrap apart from a page wrap, and a current-address read follows it. Random-length writes to random addresses, each read back over a whole page, compare the array against a page model kept in the bench.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WDAT, ST_ACK, ST_RDAT, ST_MACK
  } bus_st_t;
  localparam logic [3:0] CTRL_TAG = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_lvl  = scl_q[STAGES-1];
  assign sda_lvl  = sda_q[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  // data edges while the clock stays high frame a transfer
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int DEPTH = 256,
  parameter int PAGE  = 16,
  parameter int DW    = 8,
  parameter logic [DW-1:0] ERASED = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     commit
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(PAGE);
  localparam int PW = AW - CW;

  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] pbuf [PAGE];
  logic [PAGE-1:0] pvalid;
  logic [PW-1:0]   page_r;

  // page buffer: one slot per column, a later byte simply overwrites its slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid <= '0;
      page_r <= '0;
      for (int c = 0; c < PAGE; c++) pbuf[c] <= '0;
    end else if (clr || commit) begin
      pvalid <= '0;
    end else if (we) begin
      pbuf[wr_addr[CW-1:0]]   <= wr_data;
      pvalid[wr_addr[CW-1:0]] <= 1'b1;
      page_r                  <= wr_addr[AW-1:CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int c = 0; c < PAGE; c++)
        if (pvalid[c]) mem[{page_r, CW'(c)}] <= pbuf[c];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int TWR_CLKS = 2_500_000,
  parameter int DEPTH    = 256,
  parameter int PAGE     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(PAGE);
  localparam int TW = $clog2(TWR_CLKS + 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  bus_st_t state, nxt;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, obyte, rd_data;
  logic [AW-1:0] ptr;
  logic          mack, pend, busy;
  logic [TW-1:0] tmr;
  logic          byte_done, wr_byte, commit, buf_clr;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_lvl, .sda_lvl, .scl_rise, .scl_fall, .start_ev, .stop_ev
  );

  assign byte_done = scl_fall && (bitcnt == 4'd8) && !start_ev && !stop_ev;
  assign wr_byte   = (state == ST_WDAT) && byte_done;
  assign commit    = busy && (tmr == TW'(1));
  assign buf_clr   = !busy && (start_ev || (stop_ev && wp_i));

  eeprom_store #(.DEPTH(DEPTH), .PAGE(PAGE), .DW(8)) u_store (
    .clk, .rst_n,
    .rd_addr(ptr), .rd_data,
    .clr(buf_clr), .we(wr_byte), .wr_addr(ptr), .wr_data(shreg),
    .commit
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; nxt <= ST_IDLE; bitcnt <= '0; shreg <= '0;
      obyte <= '0; ptr <= '0; mack <= 1'b0; pend <= 1'b0;
      busy <= 1'b0; tmr <= '0; sda_oe_o <= 1'b0;
    end else begin
      if (busy) begin
        tmr <= tmr - TW'(1);
        if (tmr == TW'(1)) busy <= 1'b0;
      end
      if (start_ev) begin
        state <= ST_CTRL; bitcnt <= '0; sda_oe_o <= 1'b0;
        if (!busy) pend <= 1'b0;
      end else if (stop_ev) begin
        state <= ST_IDLE; sda_oe_o <= 1'b0; pend <= 1'b0;
        if (pend && !busy && !wp_i) begin
          busy <= 1'b1;
          tmr  <= TW'(TWR_CLKS);
        end
      end else begin
        unique case (state)
          ST_CTRL, ST_ADDR, ST_WDAT: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_CTRL) begin
                if (shreg[7:1] == {CTRL_TAG, strap_i} && !busy) begin
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK;
                  nxt      <= shreg[0] ? ST_RDAT : ST_ADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                ptr <= shreg[AW-1:0]; sda_oe_o <= 1'b1;
                state <= ST_ACK; nxt <= ST_WDAT;
              end else begin
                ptr  <= {ptr[AW-1:CW], ptr[CW-1:0] + CW'(1)};
                pend <= 1'b1; sda_oe_o <= 1'b1;
                state <= ST_ACK; nxt <= ST_WDAT;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            state  <= nxt;
            bitcnt <= '0;
            if (nxt == ST_RDAT) begin
              obyte    <= rd_data;
              sda_oe_o <= ~rd_data[7];
            end else begin
              sda_oe_o <= 1'b0;
            end
          end
          ST_RDAT: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe_o <= 1'b0; state <= ST_MACK; ptr <= ptr + AW'(1);
            end else begin
              obyte    <= {obyte[6:0], 1'b0};
              sda_oe_o <= ~obyte[6];
              bitcnt   <= bitcnt + 4'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda_lvl;
            else if (scl_fall) begin
              if (mack) begin
                state <= ST_RDAT; bitcnt <= '0;
                obyte <= rd_data; sda_oe_o <= ~rd_data[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
  import eeprom_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    scl_lvl,
  input logic    start_ev,
  input logic    stop_ev,
  input logic    busy,
  input logic    wp,
  input logic    oe,
  input bus_st_t st
);
  // R2: the slave moves SDA only while the clock is low
  a_r2_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> (!scl_lvl || $past(start_ev) || $past(stop_ev)));

  // R7: a running programming cycle keeps the slave off the bus
  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !oe);

  // R8: a Stop under write protect starts no programming cycle
  a_r8_wp_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && wp && !busy) |=> !busy);

  // R11: SDA released whenever the slave is not in a transfer
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe);
endmodule

bind eeprom_slave eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
  .stop_ev(stop_ev), .busy(busy), .wp(wp_i), .oe(sda_oe_o), .st(state)
);

// File: tb/tb_eeprom_slave.sv
module tb_eeprom_slave;
  localparam int TWR = 300;
  localparam int Q   = 5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CTRL_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CTRL_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] wbuf  [32];

  assign sda_line = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  eeprom_slave #(.TWR_CLKS(TWR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0; half();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half(); half();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; half(); scl = 1'b1; half(); half(); scl = 1'b0; half();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; half(); scl = 1'b1; half(); b = sda_line; half(); scl = 1'b0; half();
  endtask
  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] d, input bit ack_m);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!ack_m);
  endtask

  function automatic void model_write(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) model[{a[7:4], 4'(a[3:0] + i)}] = wbuf[i];
  endfunction

  task automatic do_write(input logic [7:0] a, input int n);
    bit k;
    bus_start();
    wbyte(CTRL_W, k); chk_eq("R4 control ack", k, 1);
    wbyte(a, k);      chk_eq("R4 address ack", k, 1);
    for (int i = 0; i < n; i++) begin wbyte(wbuf[i], k); chk_eq("R4 data ack", k, 1); end
    bus_stop();
  endtask

  task automatic probe(output bit k);
    bus_start(); wbyte(CTRL_W, k); bus_stop();
  endtask

  task automatic wait_prog();
    repeat (TWR + 40) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string req);
    bit k;
    logic [7:0] d;
    bus_start(); wbyte(CTRL_W, k); wbyte(a, k);
    bus_start(); wbyte(CTRL_R, k); chk_eq("R9 read control ack", k, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i != n - 1);
      chk_eq(req, d, model[8'(a + i)]);
    end
    bus_stop();
  endtask

  initial begin
    bit k;
    logic b;
    logic [7:0] d, a;
    int n;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1 reset oe", sda_oe, 0);
    do_read(8'h37, 1, "R1 erased array");

    // R2: a byte clocked without a Start is ignored
    scl = 1'b0; half();
    wbyte(CTRL_W, k); chk_eq("R2 no start no ack", k, 0);
    bus_stop();

    // R3: wrong straps
    bus_start(); wbyte({4'b1010, 3'b010, 1'b0}, k); chk_eq("R3 strap mismatch", k, 0);
    wbyte(8'h00, k); chk_eq("R3 stays off bus", k, 0);
    bus_stop();

    // R5/R7: byte write and busy polling
    wbuf[0] = 8'h5A; do_write(8'h10, 1); model_write(8'h10, 1);
    probe(k); chk_eq("R7 no ack while busy", k, 0);
    wait_prog();
    probe(k); chk_eq("R7 ack after cycle", k, 1);
    do_read(8'h10, 1, "R5 byte write");

    // R5: page wrap
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hC0 + i);
    do_write(8'h2E, 4); model_write(8'h2E, 4); wait_prog();
    do_read(8'h20, 16, "R5 page wrap");

    // R6: 20 bytes into one page
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h30 + 7 * i);
    do_write(8'h40, 20); model_write(8'h40, 20); wait_prog();
    do_read(8'h40, 16, "R6 last sixteen kept");

    // R8: write protect
    wp = 1'b1;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h10, 3);
    probe(k); chk_eq("R8 no cycle under protect", k, 1);
    wp = 1'b0;
    do_read(8'h10, 3, "R8 array unchanged");

    // R12: address-only write
    bus_start(); wbyte(CTRL_W, k); wbyte(8'h60, k); bus_stop();
    probe(k); chk_eq("R12 no cycle without data", k, 1);

    // R9/R10: rollover then current-address read
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; do_write(8'hFE, 2); model_write(8'hFE, 2); wait_prog();
    wbuf[0] = 8'hB0; do_write(8'h00, 1); model_write(8'h00, 1); wait_prog();
    do_read(8'hFE, 4, "R9 sequential rollover");
    bus_start(); wbyte(CTRL_R, k); chk_eq("R10 control ack", k, 1);
    rbyte(d, 1'b1); chk_eq("R10 current read 0", d, model[2]);
    rbyte(d, 1'b0); chk_eq("R10 current read 1", d, model[3]);
    bus_stop();

    // R11: master NACK releases the line (next byte at 0x10 starts with 0)
    bus_start(); wbyte(CTRL_W, k); wbyte(8'h0F, k);
    bus_start(); wbyte(CTRL_R, k);
    rbyte(d, 1'b0); chk_eq("R11 byte before nack", d, model[8'h0F]);
    for (int i = 0; i < 3; i++) begin get_bit(b); chk_eq("R11 line released", b, 1); end
    bus_stop();

    // random page writes
    for (int r = 0; r < 6; r++) begin
      a = 8'($urandom);
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n); model_write(a, n); wait_prog();
      do_read({a[7:4], 4'h0}, 16, "R6 random page");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule